// File: doc/BRIEF.md
# CPU Doze Cycle Throttle

This block sits between a free-running system clock and a small CPU core. It derives four quadrature phase enables from the system clock, so that one instruction cycle spans four clocks. It also produces the per-instruction-cycle enables for CPU execution and for program-memory fetch. Peripherals use the phase enables, and these never stop.

When doze is requested, the CPU and fetch enables are active for one instruction cycle out of every 2^(ratio+1) cycles. The system clock and the phase enables keep running during doze.

An interrupt can bring the core back to full speed when the recover option is set. On recovery, the block emits a one-clock pulse that clears the doze bit in the owning register, and a vector-fetch request when interrupts are globally enabled. A multi-cycle instruction that is still in progress holds off both of these.

Top module: `doze_throttle`

## Requirements
- R1: `q_en_o` is one-hot and rotates 0001, 0010, 0100, 1000 on every clock, whether doze is on or off. Reset leaves it at 0001. An instruction cycle is the four clocks that start at the 0001 phase.
- R2: While `doze_en_i` is low, `cpu_en_o` and `fetch_en_o` are high in every instruction cycle.
- R3: While throttling, `cpu_en_o` and `fetch_en_o` are high for exactly one instruction cycle out of N, where N = 2^(ratio_i+1). Ratio 000 gives N=2, 001 gives N=4, 100 gives N=32 and 111 gives N=256.
- R4: The idle counter is held at zero while doze is off. As a result, the instruction cycle in which `doze_en_i` first rises is an active one.
- R5: A change of `ratio_i` during throttling takes effect only at the next active cycle. The period that is running finishes at the old ratio.
- R6: While throttling with `roi_i` high, an `irq_i` pulses `doze_clr_o` for one clock, in the last phase (1000) of the instruction cycle. From the next instruction cycle on, the CPU runs at full speed until `doze_en_i` falls.
- R7: On such a recovery, `vec_req_o` pulses in the same clock when `gie_i` is high. When `gie_i` is low, `doze_clr_o` still pulses but `vec_req_o` stays low.
- R8: While `mc_busy_i` is high, neither `doze_clr_o` nor `vec_req_o` is asserted. Both follow at the end of the first instruction cycle in which busy is low.
- R9: With `roi_i` low, an interrupt leaves doze on. `doze_clr_o` stays low, and `vec_req_o` pulses only at the end of active cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| doze_en_i | input | 1 | Doze request bit from the control register |
| ratio_i | input | RATIO_W | Throttle ratio code, N = 2^(code+1) |
| roi_i | input | 1 | Leave doze on interrupt |
| irq_i | input | 1 | Interrupt request |
| gie_i | input | 1 | Global interrupt enable |
| mc_busy_i | input | 1 | Core is in a multi-cycle instruction |
| q_en_o | output | 4 | One-hot quadrature phase enables |
| cpu_en_o | output | 1 | CPU execution enable for this instruction cycle |
| fetch_en_o | output | 1 | Program-memory fetch enable for this instruction cycle |
| vec_req_o | output | 1 | Request to fetch the interrupt vector |
| doze_clr_o | output | 1 | Pulse that clears the doze bit |

## Verification
The bench measures the gap between active cycles at the smallest ratio, at the largest ratio and at two ratios in between. A design with an off-by-one shift or width error would show a period of half or double the expected length.

The bench also changes the ratio in the middle of a period. A design that applied the new ratio at once would cut the running period short instead of finishing it at the old ratio.

Recovery is tested three ways: with interrupts globally disabled, with a multi-cycle instruction pending, and with the recover option off. These catch a design that drops the doze clear when the vector is suppressed, one that leaves doze in the middle of an instruction, and one that raises vectors during idle cycles.

// File: rtl/doze_throttle.sv
module doze_throttle #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               doze_en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               roi_i,
  input  logic               irq_i,
  input  logic               gie_i,
  input  logic               mc_busy_i,
  output logic [3:0]         q_en_o,
  output logic               cpu_en_o,
  output logic               fetch_en_o,
  output logic               vec_req_o,
  output logic               doze_clr_o
);
  localparam int CNT_W = 1 << RATIO_W;
  localparam logic [RATIO_W-1:0] TOP = RATIO_W'(CNT_W - 1);

  logic [1:0]         phase;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   lim;
  logic [RATIO_W-1:0] ratio_q;
  logic               exit_q;
  logic               cyc_end, throttle, active, wake;

  assign cyc_end  = (phase == 2'd3);
  assign throttle = doze_en_i & ~exit_q;
  assign active   = ~throttle | (cnt == '0);
  assign wake     = cyc_end & throttle & roi_i & irq_i & ~mc_busy_i;
  assign lim      = {CNT_W{1'b1}} >> (TOP - ratio_q);

  assign q_en_o     = 4'b0001 << phase;
  assign cpu_en_o   = active;
  assign fetch_en_o = active;
  assign doze_clr_o = wake;
  assign vec_req_o  = cyc_end & irq_i & gie_i & ~mc_busy_i & (active | wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      cnt     <= '0;
      ratio_q <= '0;
      exit_q  <= 1'b0;
    end else begin
      phase <= phase + 2'd1;
      if (cyc_end) begin
        if (!throttle || cnt == lim) begin
          cnt     <= '0;
          ratio_q <= ratio_i;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (wake)
        exit_q <= 1'b1;
      else if (!doze_en_i)
        exit_q <= 1'b0;
    end
  end
endmodule

module doze_throttle_chk #(
  parameter int RATIO_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               doze_en_i,
  input logic [RATIO_W-1:0] ratio_i,
  input logic               roi_i,
  input logic               irq_i,
  input logic               gie_i,
  input logic               mc_busy_i,
  input logic [3:0]         q_en_o,
  input logic               cpu_en_o,
  input logic               fetch_en_o,
  input logic               vec_req_o,
  input logic               doze_clr_o
);
  p_qen_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(q_en_o));
  p_qen_rotate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q_en_o == {$past(q_en_o[2:0]), $past(q_en_o[3])});
  p_off_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !doze_en_i |-> (cpu_en_o && fetch_en_o));
  p_clr_last_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    doze_clr_o |-> q_en_o[3]);
  p_after_clr_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    doze_clr_o |=> cpu_en_o);
  p_vec_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> gie_i);
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mc_busy_i |-> (!doze_clr_o && !vec_req_o));
  p_no_roi_no_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !roi_i |-> !doze_clr_o);
endmodule

bind doze_throttle doze_throttle_chk #(.RATIO_W(RATIO_W)) chk_i (.*);

// File: tb/doze_throttle_tb_top.sv
module doze_throttle_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       doze_en_i = 1'b0;
  logic [2:0] ratio_i = 3'd0;
  logic       roi_i = 1'b0;
  logic       irq_i = 1'b0;
  logic       gie_i = 1'b0;
  logic       mc_busy_i = 1'b0;
  logic [3:0] q_en_o;
  logic       cpu_en_o, fetch_en_o, vec_req_o, doze_clr_o;

  int checks = 0, fails = 0;
  int clr_n = 0, vec_n = 0, vec_idle = 0;

  always #5 clk = ~clk;

  doze_throttle dut_i (
    .clk(clk), .rst_n(rst_n), .doze_en_i(doze_en_i), .ratio_i(ratio_i),
    .roi_i(roi_i), .irq_i(irq_i), .gie_i(gie_i), .mc_busy_i(mc_busy_i),
    .q_en_o(q_en_o), .cpu_en_o(cpu_en_o), .fetch_en_o(fetch_en_o),
    .vec_req_o(vec_req_o), .doze_clr_o(doze_clr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (doze_clr_o) clr_n++;
    if (vec_req_o) begin
      vec_n++;
      if (!cpu_en_o) vec_idle++;
    end
  endtask

  task automatic clear_counts();
    clr_n = 0; vec_n = 0; vec_idle = 0;
  endtask

  task automatic icycle(output logic act);
    act = cpu_en_o & fetch_en_o;
    repeat (4) step();
  endtask

  task automatic gap(output int g);
    logic a;
    g = 0;
    do begin icycle(a); g++; end while (!a && g < 1000);
  endtask

  task automatic doze_off();
    logic a;
    doze_en_i = 1'b0; irq_i = 1'b0; roi_i = 1'b0; gie_i = 1'b0; mc_busy_i = 1'b0;
    icycle(a);
  endtask

  task automatic t_reset();
    chk(q_en_o == 4'b0001, "R1 reset phase", int'(q_en_o), 1);
    chk(cpu_en_o && fetch_en_o, "R2 reset enables", int'(cpu_en_o), 1);
    chk(!doze_clr_o && !vec_req_o, "R6 reset pulses", int'(doze_clr_o), 0);
  endtask

  task automatic t_phase();
    logic [3:0] exp;
    exp = 4'b0001;
    for (int i = 0; i < 8; i++) begin
      if (q_en_o != exp) begin
        chk(1'b0, "R1 rotate", int'(q_en_o), int'(exp));
        return;
      end
      exp = {exp[2:0], exp[3]};
      step();
    end
    chk(1'b1, "R1 rotate", 0, 0);
  endtask

  task automatic t_full_speed();
    logic a;
    int n = 0;
    for (int i = 0; i < 6; i++) begin icycle(a); if (a) n++; end
    chk(n == 6, "R2 full speed", n, 6);
  endtask

  task automatic t_ratio(input logic [2:0] r);
    logic a;
    int g, exp;
    exp = 2 << r;
    ratio_i = r;
    icycle(a);
    doze_en_i = 1'b1;
    icycle(a);
    chk(a, "R4 first doze cycle active", int'(a), 1);
    gap(g);
    chk(g == exp, "R3 period", g, exp);
    gap(g);
    chk(g == exp, "R3 period repeat", g, exp);
    doze_off();
  endtask

  task automatic t_phase_in_doze();
    ratio_i = 3'd1;
    doze_en_i = 1'b1;
    t_phase();
    doze_off();
  endtask

  task automatic t_ratio_change();
    logic a;
    int g;
    ratio_i = 3'd4;
    icycle(a);
    doze_en_i = 1'b1;
    icycle(a);
    repeat (3) icycle(a);
    ratio_i = 3'd1;
    gap(g);
    chk(g == 29, "R5 old ratio finishes", g, 29);
    gap(g);
    chk(g == 4, "R5 new ratio applies", g, 4);
    doze_off();
  endtask

  task automatic t_roi(input logic gie);
    logic a;
    int n = 0;
    ratio_i = 3'd4; roi_i = 1'b1; gie_i = gie;
    icycle(a);
    doze_en_i = 1'b1;
    icycle(a);
    icycle(a);
    clear_counts();
    irq_i = 1'b1;
    icycle(a);
    irq_i = 1'b0;
    chk(clr_n == 1, "R6 doze clear pulse", clr_n, 1);
    if (gie) chk(vec_n == 1, "R7 vector with gie", vec_n, 1);
    else     chk(vec_n == 0, "R7 no vector without gie", vec_n, 0);
    for (int i = 0; i < 4; i++) begin icycle(a); if (a) n++; end
    chk(n == 4, "R6 full speed after wake", n, 4);
    doze_off();
  endtask

  task automatic t_busy();
    logic a;
    ratio_i = 3'd1; roi_i = 1'b1; gie_i = 1'b1;
    icycle(a);
    doze_en_i = 1'b1;
    mc_busy_i = 1'b1;
    clear_counts();
    irq_i = 1'b1;
    repeat (3) icycle(a);
    chk(clr_n == 0 && vec_n == 0, "R8 held while busy", clr_n + vec_n, 0);
    mc_busy_i = 1'b0;
    icycle(a);
    irq_i = 1'b0;
    chk(clr_n == 1, "R8 clear after busy", clr_n, 1);
    chk(vec_n == 1, "R8 vector after busy", vec_n, 1);
    doze_off();
  endtask

  task automatic t_no_roi();
    logic a;
    int n = 0;
    ratio_i = 3'd1; roi_i = 1'b0; gie_i = 1'b1;
    icycle(a);
    doze_en_i = 1'b1;
    clear_counts();
    irq_i = 1'b1;
    for (int i = 0; i < 8; i++) begin icycle(a); if (a) n++; end
    irq_i = 1'b0;
    chk(clr_n == 0, "R9 doze kept", clr_n, 0);
    chk(n == 2, "R9 still throttled", n, 2);
    chk(vec_n == 2, "R9 vectors per active cycle", vec_n, 2);
    chk(vec_idle == 0, "R9 no vector in idle cycle", vec_idle, 0);
    doze_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    while (q_en_o != 4'b0001) step();
    t_phase();
    t_full_speed();
    t_ratio(3'd0);
    t_ratio(3'd1);
    t_ratio(3'd4);
    t_ratio(3'd7);
    t_phase_in_doze();
    t_ratio_change();
    t_roi(1'b1);
    t_roi(1'b0);
    t_busy();
    t_no_roi();
    t_full_speed();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule